// File: doc/BRIEF.md
# Paired-Byte Control Register Receiver

This block is a write-only I2C target for a channel synthesizer and modulator. It answers one fixed address byte. After that it takes the data in two-byte pairs. The first byte of a pair is not a register index. Its most significant bit tells the block which pair it starts. A one starts the control pair: the upper control byte is followed by the lower control byte. A zero starts the frequency pair: the upper frequency byte is followed by the lower frequency byte.

One transfer may carry a single pair, or two pairs of different kinds in either order. The four bytes are presented as parallel outputs and drive the synthesizer and modulator logic.

Before any edge detection, the SCL and SDA inputs pass through a two-flop synchronizer and then a counter-based glitch filter that runs on the system clock. The block acknowledges by driving an open-drain pull-low output. A pair reaches the outputs only as a whole: both bytes are written at the moment the second byte is acknowledged.

Top module: `ctlpair_rx`

## Requirements
- R1: Only the address byte 0xCA (1100_1010, write) is acknowledged, by asserting `sda_pull_o` during the ninth clock slot. For any other address the block acknowledges nothing, and the bytes that follow in that transfer change no output.
- R2: A first data byte with bit 7 = 1 starts the control pair. It is stored to `ctl_hi_o`, and the next byte is stored to `ctl_lo_o`. Field layout:
  - `ctl_hi_o`: audio sensitivity in [6:4], carrier ratio in [3:1], positive-modulation select in [0].
  - `ctl_lo_o`: video depth in [7:5], sound subcarrier select in [4:3], test state in [2:0].
- R3: A first data byte with bit 7 = 0 starts the frequency pair. It is stored to `frq_hi_o`, and the next byte is stored to `frq_lo_o`. Field layout:
  - `frq_hi_o`: test-pattern enable in [6], divider bits 11..6 in [5:0].
  - `frq_lo_o`: divider bits 5..0 in [7:2], test-mode extension in [1:0].
- R4: Both bytes of a pair update their outputs in the same clock cycle, at the start of the second byte's acknowledge slot. No output changes after the first byte alone.
- R5: One transfer may chain a control pair and a frequency pair in either order. Both pairs are applied.
- R6: A pair opener of the same kind as the pair already completed in the transfer is not acknowledged and not applied. So is any byte after two completed pairs. The rest of that transfer is ignored.
- R7: A STOP or a repeated START that arrives before the second byte of a pair discards that pair. The outputs keep their earlier values.
- R8: All four outputs reset to 0x00. They keep their last written values until a completed pair overwrites them.
- R9: A pulse on SCL or SDA that lasts fewer than `FILT_LEN` system clocks (default 8) has no effect on reception.
- R10: `sda_pull_o` rises only while the filtered SCL is low. It is released at the SCL falling edge that ends the acknowledge slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_pull_o | output | 1 | High drives SDA low (open-drain acknowledge) |
| ctl_hi_o | output | 8 | Upper control byte |
| ctl_lo_o | output | 8 | Lower control byte |
| frq_hi_o | output | 8 | Upper frequency byte |
| frq_lo_o | output | 8 | Lower frequency byte |

## Verification
The hardest states to reach are a pair cut short by a bus condition, and a second pair that repeats the kind of the first. Both appear only after the bus has walked through a correct address and a complete first pair. Directed transfers reach them on purpose: one ends with a STOP after a lone opener, one ends with a repeated START after a lone opener, and others send two control pairs or a fifth data byte. Seeded random transfers of random length, random opener bits and an occasional wrong address or missing STOP then hit the same paths in many combinations. One directed transfer adds sub-filter pulses on SCL and SDA during bits that would otherwise look like extra clocks or a START.

// File: rtl/cpr_pkg.sv
package cpr_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RX   = 2'd1,
    ENG_ACK  = 2'd2,
    ENG_SKIP = 2'd3
  } eng_st_t;
endpackage

// File: rtl/cpr_deglitch.sv
module cpr_deglitch #(
  parameter int FILT_LEN = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          clean_q, clean_n;

  // A new level is taken over only after it has held for FILT_LEN clocks.
  always_comb begin
    cnt_n   = '0;
    clean_n = clean_q;
    if (sync_q[1] != clean_q) begin
      if (cnt_q == CW'(FILT_LEN - 1)) begin
        clean_n = sync_q[1];
      end else begin
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 2'b11;
      cnt_q   <= '0;
      clean_q <= 1'b1;
    end else begin
      sync_q  <= {sync_q[0], raw_i};
      cnt_q   <= cnt_n;
      clean_q <= clean_n;
    end
  end

  assign clean_o = clean_q;
endmodule

// File: rtl/cpr_bus_eng.sv
module cpr_bus_eng
  import cpr_pkg::*;
#(
  parameter logic [7:0] DEV_ADDR = 8'hCA
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_f,
  input  logic       sda_f,
  input  logic       data_ok_i,
  output logic [7:0] byte_o,
  output logic       ack_data_o,
  output logic       restart_o,
  output logic       pull_o
);
  eng_st_t     st_q, st_n;
  logic [3:0]  bit_q, bit_n;
  logic [7:0]  sh_q, sh_n;
  logic        addr_q, addr_n;
  logic        pull_q, pull_n;
  logic        scl_q, sda_q;
  logic        scl_rise, scl_fall, start_c, stop_c, accept;

  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_c  = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_c   = scl_f & scl_q & ~sda_q & sda_f;
  assign accept   = addr_q ? (sh_q == DEV_ADDR) : data_ok_i;

  always_comb begin
    st_n       = st_q;
    bit_n      = bit_q;
    sh_n       = sh_q;
    addr_n     = addr_q;
    pull_n     = pull_q;
    ack_data_o = 1'b0;
    if (start_c) begin
      st_n   = ENG_RX;
      bit_n  = '0;
      addr_n = 1'b1;
      pull_n = 1'b0;
    end else if (stop_c) begin
      st_n   = ENG_IDLE;
      pull_n = 1'b0;
    end else begin
      case (st_q)
        ENG_RX: begin
          if (scl_rise && bit_q < 4'd8) begin
            sh_n  = {sh_q[6:0], sda_f};
            bit_n = bit_q + 1'b1;
          end else if (scl_fall && bit_q == 4'd8) begin
            if (accept) begin
              st_n       = ENG_ACK;
              pull_n     = 1'b1;
              ack_data_o = ~addr_q;
            end else begin
              st_n = ENG_SKIP;
            end
          end
        end
        ENG_ACK: begin
          if (scl_fall) begin
            pull_n = 1'b0;
            st_n   = ENG_RX;
            bit_n  = '0;
            addr_n = 1'b0;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ENG_IDLE;
      bit_q  <= '0;
      sh_q   <= '0;
      addr_q <= 1'b0;
      pull_q <= 1'b0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      st_q   <= st_n;
      bit_q  <= bit_n;
      sh_q   <= sh_n;
      addr_q <= addr_n;
      pull_q <= pull_n;
      scl_q  <= scl_f;
      sda_q  <= sda_f;
    end
  end

  assign byte_o    = sh_q;
  assign restart_o = start_c | stop_c;
  assign pull_o    = pull_q;
endmodule

// File: rtl/cpr_pair_regs.sv
module cpr_pair_regs (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       restart_i,
  input  logic [7:0] byte_i,
  input  logic       ack_data_i,
  output logic       data_ok_o,
  output logic [7:0] ctl_hi_o,
  output logic [7:0] ctl_lo_o,
  output logic [7:0] frq_hi_o,
  output logic [7:0] frq_lo_o
);
  logic       phase_q, phase_n;
  logic       kind_q, kind_n;
  logic       last_q, last_n;
  logic [1:0] pairs_q, pairs_n;
  logic [7:0] hold_q, hold_n;
  logic       wr_ctl, wr_frq;

  // Second byte always fits; an opener fits only if the pair kind is new.
  assign data_ok_o = phase_q | (pairs_q == 2'd0) |
                     ((pairs_q == 2'd1) & (byte_i[7] != last_q));

  always_comb begin
    phase_n = phase_q;
    kind_n  = kind_q;
    last_n  = last_q;
    pairs_n = pairs_q;
    hold_n  = hold_q;
    wr_ctl  = 1'b0;
    wr_frq  = 1'b0;
    if (restart_i) begin
      phase_n = 1'b0;
      pairs_n = 2'd0;
    end else if (ack_data_i) begin
      if (!phase_q) begin
        hold_n  = byte_i;
        kind_n  = byte_i[7];
        phase_n = 1'b1;
      end else begin
        phase_n = 1'b0;
        pairs_n = pairs_q + 1'b1;
        last_n  = kind_q;
        wr_ctl  = kind_q;
        wr_frq  = ~kind_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      kind_q  <= 1'b0;
      last_q  <= 1'b0;
      pairs_q <= 2'd0;
      hold_q  <= '0;
    end else begin
      phase_q <= phase_n;
      kind_q  <= kind_n;
      last_q  <= last_n;
      pairs_q <= pairs_n;
      hold_q  <= hold_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_hi_o <= '0;
      ctl_lo_o <= '0;
    end else if (wr_ctl) begin
      ctl_hi_o <= hold_q;
      ctl_lo_o <= byte_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frq_hi_o <= '0;
      frq_lo_o <= '0;
    end else if (wr_frq) begin
      frq_hi_o <= hold_q;
      frq_lo_o <= byte_i;
    end
  end
endmodule

// File: rtl/ctlpair_rx.sv
module ctlpair_rx #(
  parameter logic [7:0] DEV_ADDR = 8'hCA,
  parameter int         FILT_LEN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic [7:0] ctl_hi_o,
  output logic [7:0] ctl_lo_o,
  output logic [7:0] frq_hi_o,
  output logic [7:0] frq_lo_o
);
  localparam int NLINE = 2;

  logic [NLINE-1:0] line_raw, line_f;
  logic [7:0]       rx_byte;
  logic             ack_data, restart, data_ok;

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < NLINE; g++) begin : g_line
    cpr_deglitch #(.FILT_LEN(FILT_LEN)) filt_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_i   (line_raw[g]),
      .clean_o (line_f[g])
    );
  end

  cpr_bus_eng #(.DEV_ADDR(DEV_ADDR)) eng_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_f      (line_f[0]),
    .sda_f      (line_f[1]),
    .data_ok_i  (data_ok),
    .byte_o     (rx_byte),
    .ack_data_o (ack_data),
    .restart_o  (restart),
    .pull_o     (sda_pull_o)
  );

  cpr_pair_regs regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart_i  (restart),
    .byte_i     (rx_byte),
    .ack_data_i (ack_data),
    .data_ok_o  (data_ok),
    .ctl_hi_o   (ctl_hi_o),
    .ctl_lo_o   (ctl_lo_o),
    .frq_hi_o   (frq_hi_o),
    .frq_lo_o   (frq_lo_o)
  );
endmodule

// File: rtl/ctlpair_rx_chk.sv
module ctlpair_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic       sda_pull_o,
  input logic [7:0] ctl_hi_o,
  input logic [7:0] ctl_lo_o,
  input logic [7:0] frq_hi_o,
  input logic [7:0] frq_lo_o
);
  // R10: the acknowledge pull starts only inside an SCL low phase
  p_ack_in_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_f);

  // R4: control pair lands together with the acknowledge of its second byte
  p_ctl_on_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctl_lo_o) |-> sda_pull_o);

  // R4: frequency pair likewise
  p_frq_on_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frq_lo_o) |-> sda_pull_o);

  // R2: a written upper control byte carries its marker bit
  p_ctl_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ctl_hi_o) |-> ctl_hi_o[7]);

  // R3: a written upper frequency byte carries a clear marker bit
  p_frq_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frq_hi_o) |-> !frq_hi_o[7]);
endmodule

bind ctlpair_rx ctlpair_rx_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_f      (line_f[0]),
  .sda_pull_o (sda_pull_o),
  .ctl_hi_o   (ctl_hi_o),
  .ctl_lo_o   (ctl_lo_o),
  .frq_hi_o   (frq_hi_o),
  .frq_lo_o   (frq_lo_o)
);

// File: tb/ctlpair_rx_tb_top.sv
module ctlpair_rx_tb_top;
  localparam int Q = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_pull_o;
  logic [7:0] ctl_hi_o, ctl_lo_o, frq_hi_o, frq_lo_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [7:0] seq [0:5];
  logic [7:0] m_ch, m_cl, m_fh, m_fl;

  always #4 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull_o;

  ctlpair_rx dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_drv), .sda_i(sda_line),
    .sda_pull_o(sda_pull_o), .ctl_hi_o(ctl_hi_o), .ctl_lo_o(ctl_lo_o),
    .frq_hi_o(frq_hi_o), .frq_lo_o(frq_lo_o)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] exp_regs();
    return {m_ch, m_cl, m_fh, m_fl};
  endfunction

  function automatic logic [31:0] act_regs();
    return {ctl_hi_o, ctl_lo_o, frq_hi_o, frq_lo_o};
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; waitc(Q);
    scl_drv = 1'b1; waitc(Q);
    sda_m = 1'b0; waitc(Q);
    scl_drv = 1'b0;
  endtask

  task automatic bus_stop();
    waitc(Q); sda_m = 1'b0; waitc(Q);
    scl_drv = 1'b1; waitc(Q);
    sda_m = 1'b1; waitc(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      waitc(Q);
      sda_m = b[i];
      if (glitch && i == 4) begin
        waitc(3); scl_drv = 1'b1; waitc(5); scl_drv = 1'b0; waitc(Q - 8);
      end else begin
        waitc(Q);
      end
      scl_drv = 1'b1;
      waitc(Q);
      if (glitch && i == 3) begin
        sda_m = ~b[i]; waitc(5); sda_m = b[i]; waitc(Q - 5);
      end else begin
        waitc(Q);
      end
      scl_drv = 1'b0;
    end
    waitc(Q); sda_m = 1'b1; waitc(Q);
    scl_drv = 1'b1; waitc(Q);
    acked = ~sda_line;
    waitc(Q);
    scl_drv = 1'b0;
    waitc(14);
    chk("R10", "pull released after slot", {31'd0, sda_pull_o}, 32'd0);
  endtask

  // Drives seq[0..n-1] as one transfer and models the expected outcome.
  task automatic xfer(input string tag, input int n, input bit do_stop, input bit glitch);
    bit alive, phase, kind, lastk, acked, exp_ack;
    int pairs;
    logic [7:0] held;
    alive = 1'b1; phase = 1'b0; kind = 1'b0; lastk = 1'b0; pairs = 0; held = '0;
    bus_start();
    for (int i = 0; i < n; i++) begin
      if (i == 0) begin
        exp_ack = (seq[0] == 8'hCA);
        alive = exp_ack;
      end else if (!alive) begin
        exp_ack = 1'b0;
      end else if (!phase) begin
        exp_ack = (pairs == 0) || (pairs == 1 && seq[i][7] != lastk);
        if (exp_ack) begin held = seq[i]; kind = seq[i][7]; phase = 1'b1; end
        else alive = 1'b0;
      end else begin
        exp_ack = 1'b1;
        phase = 1'b0; pairs++; lastk = kind;
        if (kind) begin m_ch = held; m_cl = seq[i]; end
        else begin m_fh = held; m_fl = seq[i]; end
      end
      send_byte(seq[i], glitch, acked);
      chk(tag, "ack", {31'd0, acked}, {31'd0, exp_ack});
      chk(tag, "regs after byte", act_regs(), exp_regs());
    end
    if (do_stop) begin
      bus_stop();
      chk(tag, "regs after stop", act_regs(), exp_regs());
    end
  endtask

  initial begin
    m_ch = '0; m_cl = '0; m_fh = '0; m_fl = '0;
    void'($urandom(32'd20240611));
    waitc(5);
    chk("R8", "reset regs", act_regs(), 32'd0);
    chk("R8", "reset pull", {31'd0, sda_pull_o}, 32'd0);
    rst_n = 1'b1;
    waitc(10);

    // R2 control pair with field positions
    seq[0] = 8'hCA; seq[1] = 8'hB5; seq[2] = 8'h5A;
    xfer("R2", 3, 1'b1, 1'b0);
    chk("R2", "audio sens field", {29'd0, ctl_hi_o[6:4]}, 32'd3);
    chk("R2", "subcarrier field", {30'd0, ctl_lo_o[4:3]}, 32'd3);
    // R3 frequency pair
    seq[0] = 8'hCA; seq[1] = 8'h2C; seq[2] = 8'hF1;
    xfer("R3", 3, 1'b1, 1'b0);
    chk("R3", "divider", {20'd0, frq_hi_o[5:0], frq_lo_o[7:2]}, 32'hB3C);
    // R5 chained both orders
    seq[0] = 8'hCA; seq[1] = 8'h93; seq[2] = 8'h0F; seq[3] = 8'h11; seq[4] = 8'h22;
    xfer("R5", 5, 1'b1, 1'b0);
    seq[0] = 8'hCA; seq[1] = 8'h3F; seq[2] = 8'hFF; seq[3] = 8'hE0; seq[4] = 8'h07;
    xfer("R5", 5, 1'b1, 1'b0);
    // R6 repeated kind, then third pair
    seq[0] = 8'hCA; seq[1] = 8'h81; seq[2] = 8'h01; seq[3] = 8'hC2; seq[4] = 8'h02;
    xfer("R6", 5, 1'b1, 1'b0);
    seq[0] = 8'hCA; seq[1] = 8'h85; seq[2] = 8'h01; seq[3] = 8'h05; seq[4] = 8'h02; seq[5] = 8'h86;
    xfer("R6", 6, 1'b1, 1'b0);
    // R1 wrong address, outputs held (R8)
    seq[0] = 8'hCB; seq[1] = 8'h99; seq[2] = 8'h77;
    xfer("R1 R8", 3, 1'b1, 1'b0);
    seq[0] = 8'h4A; seq[1] = 8'h19; seq[2] = 8'h27;
    xfer("R1 R8", 3, 1'b1, 1'b0);
    // R7 stop mid-pair, repeated start mid-pair
    seq[0] = 8'hCA; seq[1] = 8'hA4;
    xfer("R7", 2, 1'b1, 1'b0);
    seq[0] = 8'hCA; seq[1] = 8'h12;
    xfer("R7", 2, 1'b0, 1'b0);
    seq[0] = 8'hCA; seq[1] = 8'h13; seq[2] = 8'h34;
    xfer("R7", 3, 1'b1, 1'b0);
    // R9 sub-filter pulses on both lines
    seq[0] = 8'hCA; seq[1] = 8'hC6; seq[2] = 8'h39;
    xfer("R9", 3, 1'b1, 1'b1);

    for (int k = 0; k < 25; k++) begin
      int n;
      n = 1 + int'($urandom % 6);
      seq[0] = ($urandom % 8 == 0) ? 8'($urandom) : 8'hCA;
      for (int j = 1; j < 6; j++) seq[j] = 8'($urandom);
      xfer("RND R4", n, ($urandom % 4) != 0, 1'b0);
    end
    bus_stop();
    chk("R8", "final hold", act_regs(), exp_regs());

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule